// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a watchdog peripheral on a small register bus. A down-counter is decremented once per microsecond by a tick enable supplied from outside. Software keeps the system alive by writing a key word to the restart register, which loads the counter from a programmable reload register. The reload value is therefore the timeout in seconds multiplied by 1,000,000.

If software stops restarting the counter, it expires. Expiry sets a sticky timeout flag and flips a sticky alternate-boot flag. It also starts an external reset pulse whose length is programmed in microseconds. When enabled, it issues a single-cycle system reset request. Before expiry, a threshold packed into the upper bits of the control word can raise an early-warning interrupt. A dedicated clear register returns all sticky status to its primary state.

Top module: `wdog_timer`

## Requirements
- R1: After reset the counter (offset 0x00) reads RELOAD_RST (default 0x0098_9680), the status word reads 0, and `irq`, `sys_rst_req`, `ext_rst` and `alt_boot` are low.
- R2: Writing exactly 0x0000_4755 to offset 0x08 loads the counter from the reload register (offset 0x04), whether or not counting is enabled. Any other value written there leaves the counter unchanged.
- R3: While control bit 0 is set, the counter decreases by one on each cycle where `tick` is high. When bit 0 is cleared, the counter holds its value and is not reloaded.
- R4: A tick that arrives while counting is enabled and the counter is 1 or less is an expiry. An expiry reloads the counter, sets status bit 0 and inverts status bit 1 (mirrored on `alt_boot`).
- R5: On an expiry, `sys_rst_req` goes high for exactly one clock cycle if control bit 1 is set. If control bit 1 is clear, it stays low.
- R6: The early-warning threshold is control bits 31..10 with bits 9..0 taken as zero. When control bits 0 and 2 are both set and the counter is at or below the threshold, `irq` and status bit 2 go high. They stay high until cleared. With control bit 2 clear, `irq` stays low.
- R7: Writing a value with bit 0 set to offset 0x14 clears status bits 0, 1 and 2. A value with bit 0 clear has no effect.
- R8: Offset 0x18 holds a 20-bit field (upper bits read 0). `ext_rst` rises in the cycle after an expiry and stays high for field+1 ticks.
- R9: Offsets 0x04 and 0x0C read back what was written; control bits 9..3 read 0. The status word at offset 0x10 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle enable per microsecond |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Early-warning interrupt, sticky |
| sys_rst_req | output | 1 | One-cycle system reset request |
| ext_rst | output | 1 | External reset pulse |
| alt_boot | output | 1 | Alternate-boot indication |

## Verification
The in-line assertions check the following on every cycle:
- the counter's one-step decrement, hold when disabled, and restart load;
- the stickiness of the interrupt;
- the flip of the boot flag on expiry;
- the single-cycle width of the reset request;
- the start of the external pulse.

Some behaviours can only be shown by the bench's scenarios:
- that only the exact key word restarts the counter;
- the exact tick on which expiry occurs;
- the full pulse length in ticks;
- the threshold position within the control word;
- the clear register's bit-0 qualification.

// File: rtl/wdog_pkg.sv
// Package: shared register offsets, control/status bit positions and the
// restart key for the watchdog timer. Assumes an 8-bit byte address bus.
package wdog_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_COUNT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RESTART = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLEAR   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WIDTH   = 8'h18;

    localparam int CTRL_RUN   = 0;
    localparam int CTRL_RSTEN = 1;
    localparam int CTRL_IRQEN = 2;

    localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

    typedef struct packed {
        logic warn;     // status bit 2
        logic alt;      // status bit 1
        logic expired;  // status bit 0
    } wdog_stat_t;
endpackage

// File: rtl/wdog_regs.sv
// Register file and bus decode. Holds reload, control fields and pulse
// width; decodes restart and clear strokes; muxes read data.
// Assumes single-cycle writes and combinational reads.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int THR_LSB = 10,
    parameter int PW_W = 20,
    parameter logic [DATA_W-1:0] RELOAD_RST = 32'h0098_9680
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        cnt_val,
    input  wdog_stat_t               stat,
    output logic [DATA_W-1:0]        reload_q,
    output logic                     run_q,
    output logic                     rsten_q,
    output logic                     irqen_q,
    output logic [DATA_W-THR_LSB-1:0] thr_q,
    output logic [PW_W-1:0]          width_q,
    output logic                     restart_hit,
    output logic                     clear_hit,
    output logic [DATA_W-1:0]        bus_rdata
);
    localparam int GAP_W = THR_LSB - 3;

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata[THR_LSB-1:3];

    // Strobe decode for the write-only action registers.
    always_comb begin
        restart_hit = bus_we && (bus_addr == OFS_RESTART) && (bus_wdata == DATA_W'(RESTART_KEY));
        clear_hit   = bus_we && (bus_addr == OFS_CLEAR) && bus_wdata[0];
    end

    // Storage for the read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= RELOAD_RST;
            run_q    <= 1'b0;
            rsten_q  <= 1'b0;
            irqen_q  <= 1'b0;
            thr_q    <= '0;
            width_q  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_RELOAD: reload_q <= bus_wdata;
                OFS_CTRL: begin
                    run_q   <= bus_wdata[CTRL_RUN];
                    rsten_q <= bus_wdata[CTRL_RSTEN];
                    irqen_q <= bus_wdata[CTRL_IRQEN];
                    thr_q   <= bus_wdata[DATA_W-1:THR_LSB];
                end
                OFS_WIDTH: width_q <= bus_wdata[PW_W-1:0];
                default: ;
            endcase
        end
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            OFS_COUNT:  bus_rdata = cnt_val;
            OFS_RELOAD: bus_rdata = reload_q;
            OFS_CTRL:   bus_rdata = {thr_q, {GAP_W{1'b0}}, irqen_q, rsten_q, run_q};
            OFS_STATUS: bus_rdata = {{(DATA_W-3){1'b0}}, stat};
            OFS_WIDTH:  bus_rdata = {{(DATA_W-PW_W){1'b0}}, width_q};
            default:    bus_rdata = '0;
        endcase
    end

    assert_reload_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_RELOAD) |=> $stable(reload_q));
endmodule

// File: rtl/wdog_counter.sv
// Down-counter: decrements on tick while running, reloads on a restart
// stroke or on expiry. Restart takes priority over a coincident tick.
// Assumes tick is a one-cycle enable.
module wdog_counter #(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] RELOAD_RST = 32'h0098_9680
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              restart,
    input  logic [DATA_W-1:0] reload,
    input  logic [DATA_W-1:0] threshold,
    output logic [DATA_W-1:0] count,
    output logic              expire,
    output logic              below_thr
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Expiry event and threshold comparison.
    always_comb begin
        expire    = run && tick && !restart && (count <= ONE);
        below_thr = (count <= threshold);
    end

    // Counter register update.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= RELOAD_RST;
        else if (restart)       count <= reload;
        else if (run && tick)   count <= (count <= ONE) ? reload : count - ONE;
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !restart && count > ONE) |=> count == $past(count) - ONE);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(count));
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> count == $past(reload));
    assert_expire_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == $past(reload));
endmodule

// File: rtl/wdog_status.sv
// Sticky status flags and the single-cycle reset request. Setting events
// win over a coincident clear. Assumes expire is a one-cycle event.
module wdog_status
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic       warn_hit,
    input  logic       clear,
    input  logic       rst_en,
    output wdog_stat_t stat,
    output logic       sys_rst_req
);
    // Sticky flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            if (expire)        stat.expired <= 1'b1;
            else if (clear)    stat.expired <= 1'b0;
            if (expire)        stat.alt <= ~stat.alt;
            else if (clear)    stat.alt <= 1'b0;
            if (warn_hit)      stat.warn <= 1'b1;
            else if (clear)    stat.warn <= 1'b0;
        end
    end

    // Reset request pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_rst_req <= 1'b0;
        else        sys_rst_req <= expire && rst_en;
    end

    assert_warn_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat.warn && !clear) |=> stat.warn);
    assert_alt_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> stat.alt != $past(stat.alt));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !expire && !warn_hit) |=> (stat == '0));
    assert_req_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(rst_en));
endmodule

// File: rtl/wdog_pulse.sv
// External reset pulse: rises on fire and lasts width+1 ticks; a new fire
// restarts it. Assumes tick is a one-cycle enable.
module wdog_pulse #(
    parameter int PW_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            fire,
    input  logic [PW_W-1:0] width,
    output logic            pulse
);
    logic [PW_W-1:0] left_q;

    // Pulse state and remaining tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            left_q <= '0;
        end else if (fire) begin
            pulse  <= 1'b1;
            left_q <= width;
        end else if (pulse && tick) begin
            if (left_q == '0) pulse <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end

    assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> pulse);
    assert_pulse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !tick) |=> pulse);
endmodule

// File: rtl/wdog_timer.sv
// Top of the watchdog timer: wires the register file, counter, status
// flags and pulse generator. Assumes tick is a one-cycle 1 MHz enable.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int THR_LSB = 10,
    parameter int PW_W = 20,
    parameter logic [DATA_W-1:0] RELOAD_RST = 32'h0098_9680
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst_req,
    output logic              ext_rst,
    output logic              alt_boot
);
    logic [DATA_W-1:0]         reload_q, count, threshold;
    logic [DATA_W-THR_LSB-1:0] thr_q;
    logic [PW_W-1:0]           width_q;
    logic run_q, rsten_q, irqen_q, restart_hit, clear_hit;
    logic expire, below_thr, warn_hit;
    wdog_stat_t stat;

    // Threshold expansion and early-warning qualification.
    always_comb begin
        threshold = {thr_q, {THR_LSB{1'b0}}};
        warn_hit  = run_q && irqen_q && below_thr;
    end

    wdog_regs #(.DATA_W(DATA_W), .THR_LSB(THR_LSB), .PW_W(PW_W), .RELOAD_RST(RELOAD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .cnt_val(count), .stat(stat), .reload_q(reload_q),
        .run_q(run_q), .rsten_q(rsten_q), .irqen_q(irqen_q), .thr_q(thr_q),
        .width_q(width_q), .restart_hit(restart_hit), .clear_hit(clear_hit),
        .bus_rdata(bus_rdata));

    wdog_counter #(.DATA_W(DATA_W), .RELOAD_RST(RELOAD_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q), .restart(restart_hit),
        .reload(reload_q), .threshold(threshold), .count(count),
        .expire(expire), .below_thr(below_thr));

    wdog_status u_stat (
        .clk(clk), .rst_n(rst_n), .expire(expire), .warn_hit(warn_hit),
        .clear(clear_hit), .rst_en(rsten_q), .stat(stat), .sys_rst_req(sys_rst_req));

    wdog_pulse #(.PW_W(PW_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fire(expire), .width(width_q),
        .pulse(ext_rst));

    assign irq      = stat.warn;
    assign alt_boot = stat.alt;

    assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_req && !expire) |=> !sys_rst_req);
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic irq, sys_rst_req, ext_rst, alt_boot;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_timer uut (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq),
        .sys_rst_req(sys_rst_req), .ext_rst(ext_rst), .alt_boot(alt_boot));

    // {addr, write data, expected read-back}
    localparam logic [71:0] VEC [6] = '{
        {8'h04, 32'h0000_1234, 32'h0000_1234},   // R9 reload read-back
        {8'h0C, 32'hFFFF_FFF8, 32'hFFFF_FC00},   // R9 control, bits 9..3 read 0
        {8'h18, 32'hFFFF_FFFF, 32'h000F_FFFF},   // R8 20-bit width field
        {8'h18, 32'h0000_0002, 32'h0000_0002},   // R8 width = 2 -> 3 ticks
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},   // R9 status ignores writes
        {8'h0C, 32'h0000_0000, 32'h0000_0000}    // R9 control back to idle
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        cyc();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        rd(8'h00, v); check("R1 count", v, 32'h0098_9680);
        rd(8'h10, v); check("R1 status", v, 0);
        check("R1 outputs", {28'd0, irq, sys_rst_req, ext_rst, alt_boot}, 0);

        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], v);
            check($sformatf("table entry %0d", i), v, VEC[i][31:0]);
        end

        // R2 restart only with the exact key
        wr(8'h04, 32'd10);
        wr(8'h08, 32'h0001_4755);
        rd(8'h00, v); check("R2 wrong key ignored", v, 32'h0098_9680);
        wr(8'h08, 32'h0000_4755);
        rd(8'h00, v); check("R2 key reloads", v, 32'd10);

        // R3 counting and hold
        pulse_tick();
        rd(8'h00, v); check("R3 idle holds", v, 32'd10);
        wr(8'h0C, 32'h1);
        repeat (3) pulse_tick();
        rd(8'h00, v); check("R3 three steps", v, 32'd7);
        wr(8'h0C, 32'h0);
        pulse_tick();
        rd(8'h00, v); check("R3 stop without reload", v, 32'd7);

        // R4 R5 R8 expiry with reset request
        wr(8'h04, 32'd5);
        wr(8'h08, 32'h4755);
        wr(8'h0C, 32'h3);
        repeat (4) pulse_tick();
        check("R5 no request early", {31'd0, sys_rst_req}, 0);
        pulse_tick();
        check("R5 request high", {31'd0, sys_rst_req}, 1);
        check("R8 pulse starts", {31'd0, ext_rst}, 1);
        rd(8'h00, v); check("R4 reload on expiry", v, 32'd5);
        rd(8'h10, v); check("R4 status", v, 32'h3);
        cyc();
        check("R5 request one cycle", {31'd0, sys_rst_req}, 0);
        repeat (2) pulse_tick();
        check("R8 pulse after 2 ticks", {31'd0, ext_rst}, 1);
        pulse_tick();
        check("R8 pulse ends after 3 ticks", {31'd0, ext_rst}, 0);
        wr(8'h0C, 32'h0);

        // R7 clear qualification
        wr(8'h14, 32'h0000_0002);
        rd(8'h10, v); check("R7 bit0 clear ignored", v, 32'h3);
        wr(8'h14, 32'h1);
        rd(8'h10, v); check("R7 cleared", v, 0);
        check("R7 alt low", {31'd0, alt_boot}, 0);

        // R4 R5 repeated expiry, reset request disabled
        wr(8'h04, 32'd1);
        wr(8'h08, 32'h4755);
        wr(8'h0C, 32'h1);
        pulse_tick();
        check("R5 gated off", {31'd0, sys_rst_req}, 0);
        check("R4 alt set", {31'd0, alt_boot}, 1);
        pulse_tick();
        rd(8'h10, v); check("R4 alt flips back", v, 32'h1);
        wr(8'h0C, 32'h0);
        wr(8'h14, 32'h1);

        // R6 early warning gated by control bit 2
        wr(8'h04, 32'd2050);
        wr(8'h08, 32'h4755);
        wr(8'h0C, (32'd2 << 10) | 32'h1);
        repeat (2) pulse_tick();
        repeat (2) cyc();
        check("R6 gated by enable", {31'd0, irq}, 0);
        wr(8'h08, 32'h4755);
        wr(8'h0C, (32'd2 << 10) | 32'h5);
        pulse_tick();
        cyc();
        check("R6 above threshold", {31'd0, irq}, 0);
        pulse_tick();
        cyc();
        check("R6 at threshold", {31'd0, irq}, 1);
        wr(8'h0C, 32'h0);
        rd(8'h10, v); check("R6 sticky status bit 2", v, 32'h4);
        wr(8'h08, 32'h4755);
        wr(8'h14, 32'h1);
        check("R7 irq cleared", {31'd0, irq}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule